// File: doc/BRIEF.md
# PCM Time-Slot Serial Receiver

This block receives serial PCM audio as a slave of an external master. The master supplies the bit clock, the frame sync and the data line. The block samples all three with the system clock through two-flop synchronisers and finds the bit-clock edges from the synchronised copy. A frame is a fixed number of time slots. The slot length in bit clocks and the sample width are set separately, and a per-slot mask chooses which slots yield samples. Each sample arrives MSB first and is returned left justified in a 16-bit word. The word goes out on a valid/ready port toward a packing FIFO, together with the index of its slot.

Data can be latched on either bit-clock edge. Frame sync is always taken on the rising edge. Register-driven enable and soft-reset inputs gate capture. A sticky flag records any word lost because the consumer was not ready.

Top module: `pcm_slot_rx`

## Requirements
- R1: After rst_n is deasserted, sample_valid and overflow are 0.
- R2: A frame starts at a rising bit-clock edge where pcm_fs is seen high after being low at the previous rising edge. Bit 0 of slot 0 is the first data latch at or after that edge.
- R3: When latch_on_fall=1, pcm_din is latched on falling bit-clock edges. When latch_on_fall=0, it is latched on rising edges.
- R4: Each slot lasts slot_len_m1+1 bit clocks, and slot s begins at bit s*(slot_len_m1+1) of the frame.
- R5: A sample takes the first data_msb+1 bits of its slot, MSB first. It is placed with its MSB at bit 15 of sample_data, and the lower bits are 0. The remaining bits of the slot have no effect. data_msb must not exceed slot_len_m1.
- R6: Only slot s with slot_mask[s]=1 produces a sample, and sample_slot gives s.
- R7: After the last of the NSLOT slots, further bits are ignored until the next frame start. A frame start in mid-frame restarts the slot and bit counts and discards any partial sample.
- R8: While sample_valid=1 and sample_ready=0, sample_valid stays 1 and sample_data and sample_slot stay unchanged.
- R9: A sample that completes while sample_valid=1 and sample_ready=0 is dropped, and overflow becomes 1 and stays 1 until soft_reset.
- R10: With enable=0 no frame starts and no sample is produced.
- R11: soft_reset=1 clears sample_valid, overflow and the framing state by the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Capture enable |
| soft_reset | input | 1 | Synchronous clear of receiver state |
| latch_on_fall | input | 1 | 1: latch data on bit-clock falling edge; 0: on rising edge |
| slot_len_m1 | input | LEN_W | Slot length in bit clocks minus one |
| data_msb | input | 4 | Sample width minus one |
| slot_mask | input | NSLOT | Per-slot capture enable |
| pcm_bclk | input | 1 | Serial bit clock from the master |
| pcm_fs | input | 1 | Frame sync, active high |
| pcm_din | input | 1 | Serial data |
| sample_ready | input | 1 | Consumer ready |
| sample_valid | output | 1 | Sample available |
| sample_data | output | 16 | Left-justified sample |
| sample_slot | output | SW | Slot index of the sample |
| overflow | output | 1 | Sticky lost-sample flag |

## Verification
Two cases are the hardest to reach from the ports.

The first is a frame sync that arrives while a slot is partly shifted in. The bench reaches it by cutting a frame short after a few bits and then starting a new frame, which must yield only the new frame's samples.

The second is an overflow. The bench holds ready low through a frame with two masked-in slots. It then checks that the first word is held, the second is lost and the flag is set, before clearing everything with soft reset.

Random frames then vary edge, slot length, width, mask and data bits.

// File: rtl/pcm_slot_rx.sv
module pcm_slot_rx #(
  parameter int NSLOT = 4,
  parameter int LEN_W = 5,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             soft_reset,
  input  logic             latch_on_fall,
  input  logic [LEN_W-1:0] slot_len_m1,
  input  logic [3:0]       data_msb,
  input  logic [NSLOT-1:0] slot_mask,
  input  logic             pcm_bclk,
  input  logic             pcm_fs,
  input  logic             pcm_din,
  input  logic             sample_ready,
  output logic             sample_valid,
  output logic [15:0]      sample_data,
  output logic [SW-1:0]    sample_slot,
  output logic             overflow
);

  logic [2:0]       bclk_sy;
  logic [1:0]       fs_sy, din_sy;
  logic             fs_prev, in_frame;
  logic [LEN_W-1:0] bit_cnt;
  logic [SW-1:0]    slot_cnt;
  logic [14:0]      shreg;

  logic rise, fall, run, fs_start, data_edge, proc;
  logic [LEN_W-1:0] cur_bit;
  logic [SW-1:0]    cur_slot;
  logic [15:0]      word_next, aligned;
  logic             in_width, word_done, take, end_slot, last_slot;

  assign rise      = bclk_sy[1] & ~bclk_sy[2];
  assign fall      = ~bclk_sy[1] & bclk_sy[2];
  assign run       = enable & ~soft_reset;
  assign fs_start  = run & rise & fs_sy[1] & ~fs_prev;
  assign data_edge = latch_on_fall ? fall : rise;
  assign proc      = run & data_edge & (in_frame | fs_start);
  assign cur_bit   = fs_start ? '0 : bit_cnt;
  assign cur_slot  = fs_start ? '0 : slot_cnt;
  assign word_next = {shreg, din_sy[1]};
  assign aligned   = word_next << (4'd15 - data_msb);
  assign in_width  = cur_bit <= LEN_W'(data_msb);
  assign word_done = proc & (cur_bit == LEN_W'(data_msb));
  assign take      = word_done & slot_mask[cur_slot];
  assign end_slot  = cur_bit == slot_len_m1;
  assign last_slot = cur_slot == SW'(NSLOT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_sy <= '0;
      fs_sy   <= '0;
      din_sy  <= '0;
    end else begin
      bclk_sy <= {bclk_sy[1:0], pcm_bclk};
      fs_sy   <= {fs_sy[0], pcm_fs};
      din_sy  <= {din_sy[0], pcm_din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev      <= 1'b1;
      in_frame     <= 1'b0;
      bit_cnt      <= '0;
      slot_cnt     <= '0;
      shreg        <= '0;
      sample_valid <= 1'b0;
      sample_data  <= '0;
      sample_slot  <= '0;
      overflow     <= 1'b0;
    end else if (soft_reset) begin
      fs_prev      <= 1'b1;
      in_frame     <= 1'b0;
      bit_cnt      <= '0;
      slot_cnt     <= '0;
      shreg        <= '0;
      sample_valid <= 1'b0;
      overflow     <= 1'b0;
    end else begin
      if (rise) fs_prev <= fs_sy[1];
      if (!enable) in_frame <= 1'b0;
      if (fs_start) begin
        in_frame <= 1'b1;
        bit_cnt  <= '0;
        slot_cnt <= '0;
        shreg    <= '0;
      end
      if (proc) begin
        if (in_width) shreg <= word_next[14:0];
        if (end_slot) begin
          bit_cnt <= '0;
          shreg   <= '0;
          if (last_slot) in_frame <= 1'b0;
          else           slot_cnt <= cur_slot + 1'b1;
        end else begin
          bit_cnt <= cur_bit + 1'b1;
        end
      end
      if (sample_valid && sample_ready) sample_valid <= 1'b0;
      if (take) begin
        if (sample_valid && !sample_ready) overflow <= 1'b1;
        else begin
          sample_valid <= 1'b1;
          sample_data  <= aligned;
          sample_slot  <= cur_slot;
        end
      end
    end
  end

endmodule

// File: rtl/pcm_slot_rx_chk.sv
module pcm_slot_rx_chk #(
  parameter int NSLOT = 4,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
)(
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             soft_reset,
  input logic [NSLOT-1:0] slot_mask,
  input logic [3:0]       data_msb,
  input logic             sample_ready,
  input logic             sample_valid,
  input logic [15:0]      sample_data,
  input logic [SW-1:0]    sample_slot,
  input logic             overflow
);

  logic [NSLOT-1:0] mask_d;
  logic [3:0]       msb_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_d <= '0;
      msb_d  <= '0;
    end else begin
      mask_d <= slot_mask;
      msb_d  <= data_msb;
    end
  end

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && !sample_ready && !soft_reset |=> sample_valid && $stable(sample_data) && $stable(sample_slot)); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !soft_reset |=> overflow); // R9

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> !sample_valid && !overflow); // R11

  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !sample_valid |=> !sample_valid); // R10

  AST_MASKED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_valid) |-> mask_d[sample_slot]); // R6

  AST_LEFT_JUST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_valid) |-> (sample_data & (16'hFFFF >> (5'(msb_d) + 5'd1))) == 16'h0); // R5

endmodule

bind pcm_slot_rx pcm_slot_rx_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .soft_reset(soft_reset),
  .slot_mask(slot_mask), .data_msb(data_msb), .sample_ready(sample_ready),
  .sample_valid(sample_valid), .sample_data(sample_data),
  .sample_slot(sample_slot), .overflow(overflow)
);

// File: tb/pcm_slot_rx_test.sv
`timescale 1ns/1ps
module pcm_slot_rx_test;
  localparam int NSLOT = 4;
  localparam int LEN_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, soft_reset = 1'b0, latch_on_fall = 1'b0;
  logic [LEN_W-1:0] slot_len_m1 = 5'd15;
  logic [3:0] data_msb = 4'd15;
  logic [NSLOT-1:0] slot_mask = 4'b0001;
  logic pcm_bclk = 1'b0, pcm_fs = 1'b0, pcm_din = 1'b0;
  logic sample_ready = 1'b1;
  logic sample_valid, overflow;
  logic [15:0] sample_data;
  logic [1:0] sample_slot;

  pcm_slot_rx #(.NSLOT(NSLOT), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .soft_reset(soft_reset),
    .latch_on_fall(latch_on_fall), .slot_len_m1(slot_len_m1), .data_msb(data_msb),
    .slot_mask(slot_mask), .pcm_bclk(pcm_bclk), .pcm_fs(pcm_fs), .pcm_din(pcm_din),
    .sample_ready(sample_ready), .sample_valid(sample_valid), .sample_data(sample_data),
    .sample_slot(sample_slot), .overflow(overflow)
  );

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;
  bit fb [0:255];
  logic [17:0] exp_q[$];
  logic [17:0] got_q[$];

  always @(negedge clk)
    if (rst_n && sample_valid && sample_ready) got_q.push_back({sample_slot, sample_data});

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic bit_period(bit fs_v, bit b);
    @(negedge clk);
    pcm_bclk = 1'b0;
    pcm_fs = fs_v;
    if (!latch_on_fall) pcm_din = b;
    repeat (3) @(negedge clk);
    pcm_bclk = 1'b1;
    if (latch_on_fall) pcm_din = b;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(int nbits);
    for (int i = 0; i < 3; i++) bit_period(1'b0, 1'($urandom));
    for (int k = 0; k < nbits; k++) bit_period(k == 0, fb[k]);
    for (int i = 0; i < 3; i++) bit_period(1'b0, 1'($urandom));
    repeat (20) @(negedge clk);
  endtask

  function automatic logic [17:0] word_of(int s);
    int len = int'(slot_len_m1) + 1;
    int w = int'(data_msb) + 1;
    logic [15:0] v = '0;
    for (int i = 0; i < w; i++) v[15 - i] = fb[s * len + i];
    return {2'(s), v};
  endfunction

  task automatic add_expected(int nbits);
    int len = int'(slot_len_m1) + 1;
    int w = int'(data_msb) + 1;
    for (int s = 0; s < NSLOT; s++)
      if (slot_mask[s] && (s * len + w <= nbits)) exp_q.push_back(word_of(s));
  endtask

  task automatic fill_random(int n);
    for (int k = 0; k < n; k++) fb[k] = 1'($urandom);
  endtask

  task automatic compare(string req);
    check(got_q.size() == exp_q.size(), {req, " count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      check(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sample_valid == 1'b0, "R1 valid", sample_valid, 0);
    check(overflow == 1'b0, "R1 overflow", overflow, 0);
    enable = 1'b1;

    // R2 R4 R5: rising-edge latch, 16-clock slots, 16-bit samples, slot 0
    latch_on_fall = 1'b0; slot_len_m1 = 5'd15; data_msb = 4'd15; slot_mask = 4'b0001;
    fill_random(64); add_expected(64); send(64);
    compare("R2 rising latch slot0");

    // R3: falling-edge latch
    latch_on_fall = 1'b1; slot_mask = 4'b1111;
    fill_random(64); add_expected(64); send(64);
    compare("R3 falling latch");

    // R7: partial frame cut short, new frame start discards it
    fill_random(5); add_expected(5); send(5);
    fill_random(64); add_expected(64); send(64);
    compare("R7 restart discards partial");

    // R7: bits past the last slot are ignored
    latch_on_fall = 1'b0; slot_len_m1 = 5'd3; data_msb = 4'd3; slot_mask = 4'b1111;
    fill_random(40); add_expected(40); send(40);
    compare("R7 idle after last slot");

    // R6 R5: sparse mask, width shorter than slot
    slot_len_m1 = 5'd7; data_msb = 4'd5; slot_mask = 4'b1010;
    fill_random(32); add_expected(32); send(32);
    compare("R6 mask and narrow width");

    // R5: one-bit samples
    latch_on_fall = 1'b1; slot_len_m1 = 5'd31; data_msb = 4'd0; slot_mask = 4'b0110;
    fill_random(128); add_expected(128); send(128);
    compare("R5 single-bit width");

    // R8 R9: consumer stalled across two masked slots
    latch_on_fall = 1'b0; slot_len_m1 = 5'd7; data_msb = 4'd7; slot_mask = 4'b0011;
    @(posedge clk); #1 sample_ready = 1'b0;
    fill_random(32); send(32);
    check(sample_valid == 1'b1, "R8 held valid", sample_valid, 1);
    check({sample_slot, sample_data} == word_of(0), "R8 held first word",
          {sample_slot, sample_data}, word_of(0));
    check(overflow == 1'b1, "R9 overflow set", overflow, 1);
    repeat (5) @(negedge clk);
    check(overflow == 1'b1, "R9 overflow sticky", overflow, 1);

    // R11: soft reset clears
    @(posedge clk); #1 soft_reset = 1'b1;
    @(posedge clk); #1 soft_reset = 1'b0;
    @(negedge clk);
    check(sample_valid == 1'b0, "R11 valid cleared", sample_valid, 0);
    check(overflow == 1'b0, "R11 overflow cleared", overflow, 0);
    @(posedge clk); #1 sample_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(got_q.size() == 0, "R11 nothing delivered", got_q.size(), 0);

    // R10: disabled receiver ignores a frame
    enable = 1'b0; slot_mask = 4'b1111;
    fill_random(32); send(32);
    compare("R10 disabled");
    check(overflow == 1'b0, "R10 no overflow", overflow, 0);
    enable = 1'b1;
    fill_random(32); add_expected(32); send(32);
    compare("R10 re-enabled");

    // Random frames
    for (int f = 0; f < 12; f++) begin
      int len;
      latch_on_fall = 1'($urandom);
      slot_len_m1 = 5'(3 + $urandom_range(0, 28));
      len = int'(slot_len_m1) + 1;
      data_msb = 4'($urandom_range(0, (len > 16) ? 15 : len - 1));
      slot_mask = 4'($urandom);
      fill_random(len * NSLOT);
      add_expected(len * NSLOT);
      send(len * NSLOT);
      compare("R4 random frame");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule